// File: doc/BRIEF.md
# CPU Interrupt Acceptance Unit

This block sits beside a processor core and decides, on every clock edge, whether the core should start servicing a hardware interrupt. The core supplies the fields of its current status register. The block answers with a registered one-cycle take strobe and a wake signal. The wake signal tells an idle core that there is work waiting. Vector selection, exception entry and register-set switching are left to the core.

A build-time parameter selects one of two variants.

- **Internal variant.** Level-sensitive request lines are captured into a pending register, which software can only read. A software-loaded enable register masks them. Acceptance needs the global interrupt-enable bit and at least one line that is both pending and enabled.
- **External variant.** A single request arrives from an outside controller. It carries a requested priority level, a requested register-set number and a non-maskable flag. Acceptance compares these against the status fields:
  - A non-maskable request is refused only while a non-maskable handler is already running.
  - A maskable request must beat the current level.
  - A maskable request aimed at the current register set also needs the register-set interrupt-enable bit.

Top module: `irq_accept`

## Requirements
- R1: A synchronous active-high reset clears the pending register, the enable register and the take strobe; all three read 0 in the first cycle after reset.
- R2: In the internal variant, bit i of `pend_o` equals the level that `irq_lines[i]` had at the previous rising clock edge.
- R3: In the internal variant, when `en_we` is 1 at a rising edge, `enab_o` takes the value of `en_wdata` from that edge onward; otherwise it holds.
- R4: In the internal variant, `take` is 1 in the cycle after an edge only when `st_pie` was 1 and (`irq_lines` AND `enab_o`) was nonzero at that edge. The enable value used is the one held before any write at that same edge.
- R5: In the internal variant, `wake` is 1 exactly when `pend_o` is nonzero.
- R6: In the external variant, `wake` equals `ext_req` in the same cycle, with no register between them.
- R7: In the external variant, a request with `ext_nmi`=1 is taken exactly when `st_nmi` is 0. `st_pie`, the levels and the register sets have no effect on it.
- R8: In the external variant, a request with `ext_nmi`=0 is refused when `st_pie` is 0. It is also refused when `ext_lvl` (6-bit unsigned) is less than or equal to `st_il`.
- R9: In the external variant, a maskable request that passes R8 is taken when `ext_set` differs from `st_crs`. When the two are equal, it is taken only if `st_rsie` is 1.
- R10: `take` never stays high on two consecutive cycles. While the acceptance condition holds continuously, `take` pulses on every second cycle.
- R11: In the external variant, writes to the enable register are ignored: `enab_o` and `pend_o` read 0. With `ext_req` at 0, `take` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_pie | input | 1 | Status: global interrupt enable |
| st_nmi | input | 1 | Status: non-maskable handler active |
| st_rsie | input | 1 | Status: register-set interrupt enable |
| st_il | input | LVL_W | Status: current interrupt level |
| st_crs | input | SET_W | Status: current register set |
| irq_lines | input | NUM_LINES | Internal variant: level request lines |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | NUM_LINES | Enable register write data |
| ext_req | input | 1 | External variant: request present |
| ext_nmi | input | 1 | External variant: request is non-maskable |
| ext_lvl | input | LVL_W | External variant: requested level |
| ext_set | input | SET_W | External variant: requested register set |
| take | output | 1 | Registered one-cycle take-interrupt strobe |
| wake | output | 1 | Work pending for an idle core |
| pend_o | output | NUM_LINES | Pending register contents |
| enab_o | output | NUM_LINES | Enable register contents |

## Verification

Two instances are built, one per variant, and each is exercised with a sweep.

- **Internal variant.** Each request line is walked one at a time against two complementary enable masks and both settings of the global enable. A design that ignored the enable mask, or that gated on the wrong bit, would take on lines whose enable bit is clear.
- **External variant.** The non-maskable flag, the status NMI bit, global enable, RSIE and same-or-different register set are all swept. Levels and current levels are crossed at 0, 1, 2 and 63, so that equal values and the top code are both covered. An off-by-one `>=` comparator would take on equal levels. A missing NMI override would refuse whenever PIE is clear.
- **Held condition.** A request that stays asserted must produce alternating pulses. A plain registered grant would instead hold `take` high.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic {
        CTRL_INTERNAL = 1'b0,
        CTRL_EXTERNAL = 1'b1
    } ctrl_mode_e;

endpackage

// File: rtl/irq_internal_eval.sv
module irq_internal_eval #(
    parameter int NUM_LINES = 32
) (
    input  logic                 pie,
    input  logic [NUM_LINES-1:0] lines,
    input  logic [NUM_LINES-1:0] enab,
    output logic                 grant
);
    logic [NUM_LINES-1:0] live;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LINES; gi++) begin : g_mask
            assign live[gi] = lines[gi] & enab[gi];
        end
    endgenerate

    assign grant = pie & (|live);
endmodule

// File: rtl/irq_external_eval.sv
module irq_external_eval #(
    parameter int LVL_W = 6,
    parameter int SET_W = 6
) (
    input  logic             req,
    input  logic             req_nmi,
    input  logic [LVL_W-1:0] req_lvl,
    input  logic [SET_W-1:0] req_set,
    input  logic             pie,
    input  logic             nmi_active,
    input  logic             rsie,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic [SET_W-1:0] cur_set,
    output logic             grant
);
    logic lvl_above;
    logic set_ok;
    logic maskable_ok;

    always_comb begin
        lvl_above   = req_lvl > cur_lvl;
        set_ok      = (req_set != cur_set) | rsie;
        maskable_ok = pie & lvl_above & set_ok;
        if (!req) begin
            grant = 1'b0;
        end else if (req_nmi) begin
            grant = ~nmi_active;
        end else begin
            grant = maskable_ok;
        end
    end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_accept_pkg::*;
#(
    parameter ctrl_mode_e MODE      = CTRL_INTERNAL,
    parameter int         NUM_LINES = 32,
    parameter int         LVL_W     = 6,
    parameter int         SET_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_pie,
    input  logic                 st_nmi,
    input  logic                 st_rsie,
    input  logic [LVL_W-1:0]     st_il,
    input  logic [SET_W-1:0]     st_crs,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 en_we,
    input  logic [NUM_LINES-1:0] en_wdata,
    input  logic                 ext_req,
    input  logic                 ext_nmi,
    input  logic [LVL_W-1:0]     ext_lvl,
    input  logic [SET_W-1:0]     ext_set,
    output logic                 take,
    output logic                 wake,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] enab_o
);
    localparam bit IS_EXT = (MODE == CTRL_EXTERNAL);

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] enab;
        logic                 take;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic       grant_int;
    logic       grant_ext;
    logic       grant;

    irq_internal_eval #(.NUM_LINES(NUM_LINES)) u_int (
        .pie   (st_pie),
        .lines (irq_lines),
        .enab  (st_q.enab),
        .grant (grant_int)
    );

    irq_external_eval #(.LVL_W(LVL_W), .SET_W(SET_W)) u_ext (
        .req        (ext_req),
        .req_nmi    (ext_nmi),
        .req_lvl    (ext_lvl),
        .req_set    (ext_set),
        .pie        (st_pie),
        .nmi_active (st_nmi),
        .rsie       (st_rsie),
        .cur_lvl    (st_il),
        .cur_set    (st_crs),
        .grant      (grant_ext)
    );

    assign grant = IS_EXT ? grant_ext : grant_int;

    always_comb begin
        st_d = st_q;
        if (IS_EXT) begin
            st_d.pend = '0;
            st_d.enab = '0;
        end else begin
            st_d.pend = irq_lines;
            if (en_we) begin
                st_d.enab = en_wdata;
            end
        end
        st_d.take = grant & ~st_q.take;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign take   = st_q.take;
    assign pend_o = st_q.pend;
    assign enab_o = st_q.enab;
    assign wake   = IS_EXT ? ext_req : (|st_q.pend);
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
    import irq_accept_pkg::*;
#(
    parameter ctrl_mode_e MODE      = CTRL_INTERNAL,
    parameter int         NUM_LINES = 32,
    parameter int         LVL_W     = 6,
    parameter int         SET_W     = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 st_pie,
    input logic                 st_nmi,
    input logic                 st_rsie,
    input logic [LVL_W-1:0]     st_il,
    input logic [SET_W-1:0]     st_crs,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 ext_req,
    input logic                 ext_nmi,
    input logic [LVL_W-1:0]     ext_lvl,
    input logic                 take,
    input logic [NUM_LINES-1:0] pend_o,
    input logic [NUM_LINES-1:0] enab_o
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    generate
        if (MODE == CTRL_INTERNAL) begin : g_int_chk
            a_r2_pend_mirror: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> pend_o == $past(irq_lines));
            a_r4_no_take_without_pie: assert property (@(posedge clk) disable iff (rst)
                !st_pie |=> !take);
        end else begin : g_ext_chk
            a_r7_nmi_taken: assert property (@(posedge clk) disable iff (rst)
                (ext_req && ext_nmi && !st_nmi && !take) |=> take);
            a_r8_maskable_level: assert property (@(posedge clk) disable iff (rst)
                (!ext_nmi && (ext_lvl <= st_il)) |=> !take);
            a_r11_regs_zero: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (pend_o == '0) && (enab_o == '0));
        end
    endgenerate
endmodule

bind irq_accept irq_accept_chk #(
    .MODE(MODE), .NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .SET_W(SET_W)
) u_chk (
    .clk(clk), .rst(rst), .st_pie(st_pie), .st_nmi(st_nmi), .st_rsie(st_rsie),
    .st_il(st_il), .st_crs(st_crs), .irq_lines(irq_lines), .ext_req(ext_req),
    .ext_nmi(ext_nmi), .ext_lvl(ext_lvl), .take(take), .pend_o(pend_o),
    .enab_o(enab_o)
);

// File: tb/irq_accept_test.sv
module irq_accept_test;
    import irq_accept_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    // shared status inputs
    logic        st_pie = 0, st_nmi = 0, st_rsie = 0;
    logic [5:0]  st_il = 0, st_crs = 0;
    logic [31:0] irq_lines = 0, en_wdata = 0;
    logic        en_we = 0;
    logic        ext_req = 0, ext_nmi = 0;
    logic [5:0]  ext_lvl = 0, ext_set = 0;

    logic        i_take, i_wake, e_take, e_wake;
    logic [31:0] i_pend, i_enab, e_pend, e_enab;

    irq_accept #(.MODE(CTRL_INTERNAL)) uut (
        .clk(clk), .rst(rst), .st_pie(st_pie), .st_nmi(st_nmi), .st_rsie(st_rsie),
        .st_il(st_il), .st_crs(st_crs), .irq_lines(irq_lines), .en_we(en_we),
        .en_wdata(en_wdata), .ext_req(ext_req), .ext_nmi(ext_nmi),
        .ext_lvl(ext_lvl), .ext_set(ext_set), .take(i_take), .wake(i_wake),
        .pend_o(i_pend), .enab_o(i_enab)
    );

    irq_accept #(.MODE(CTRL_EXTERNAL)) uut_ext (
        .clk(clk), .rst(rst), .st_pie(st_pie), .st_nmi(st_nmi), .st_rsie(st_rsie),
        .st_il(st_il), .st_crs(st_crs), .irq_lines(irq_lines), .en_we(en_we),
        .en_wdata(en_wdata), .ext_req(ext_req), .ext_nmi(ext_nmi),
        .ext_lvl(ext_lvl), .ext_set(ext_set), .take(e_take), .wake(e_wake),
        .pend_o(e_pend), .enab_o(e_enab)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // advance one clock; inputs change at negedge, outputs are read there
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [5:0] pick(input int k);
        case (k)
            0: pick = 6'd0;
            1: pick = 6'd1;
            2: pick = 6'd2;
            default: pick = 6'd63;
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] en_pat;
        @(negedge clk);
        step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 take", {31'd0, i_take}, 32'd0);
        chk("R1 pend", i_pend, 32'd0);
        chk("R1 enab", i_enab, 32'd0);
        chk("R1 ext take", {31'd0, e_take}, 32'd0);

        // internal variant sweep
        for (int p = 0; p < 2; p++) begin
            en_pat   = (p == 0) ? 32'hA5A5_0F0F : 32'h5A5A_F0F0;
            en_wdata = en_pat;
            en_we    = 1'b1;
            step();
            en_we = 1'b0;
            chk("R3 enable load", i_enab, en_pat);
            chk("R11 ext enable ignored", e_enab, 32'd0);
            for (int b = 0; b < 32; b++) begin
                for (int pie = 0; pie < 2; pie++) begin
                    st_pie    = pie[0];
                    irq_lines = 32'd1 << b;
                    step();
                    chk("R2 pending", i_pend, 32'd1 << b);
                    chk("R5 wake", {31'd0, i_wake}, 32'd1);
                    chk("R4 take", {31'd0, i_take}, {31'd0, pie[0] & en_pat[b]});
                    chk("R11 ext pend zero", e_pend, 32'd0);
                    chk("R11 ext no take idle", {31'd0, e_take}, 32'd0);
                    irq_lines = 32'd0;
                    step();
                    chk("R4 idle take", {31'd0, i_take}, 32'd0);
                    chk("R5 idle wake", {31'd0, i_wake}, 32'd0);
                end
            end
        end

        // R4: write at same edge uses old enable (old = 5A5AF0F0, bit0 clear)
        st_pie    = 1'b1;
        irq_lines = 32'h0000_0001;
        en_wdata  = 32'hFFFF_FFFF;
        en_we     = 1'b1;
        step();
        en_we = 1'b0;
        chk("R4 old enable used", {31'd0, i_take}, 32'd0);
        chk("R3 enable all", i_enab, 32'hFFFF_FFFF);
        // R10 held condition: next cycles alternate 1,0,1
        step();
        chk("R10 pulse a", {31'd0, i_take}, 32'd1);
        step();
        chk("R10 gap", {31'd0, i_take}, 32'd0);
        step();
        chk("R10 pulse b", {31'd0, i_take}, 32'd1);
        irq_lines = 32'd0;
        st_pie    = 1'b0;
        step();

        // external variant sweep
        st_crs = 6'd5;
        for (int nr = 0; nr < 2; nr++)
        for (int sn = 0; sn < 2; sn++)
        for (int pie = 0; pie < 2; pie++)
        for (int rs = 0; rs < 2; rs++)
        for (int eq = 0; eq < 2; eq++)
        for (int lk = 0; lk < 4; lk++)
        for (int ik = 0; ik < 4; ik++) begin
            logic exp_t;
            ext_nmi = nr[0];
            st_nmi  = sn[0];
            st_pie  = pie[0];
            st_rsie = rs[0];
            ext_set = eq[0] ? 6'd5 : 6'd6;
            ext_lvl = pick(lk);
            st_il   = pick(ik);
            ext_req = 1'b1;
            #1;
            chk("R6 wake follows req", {31'd0, e_wake}, 32'd1);
            if (nr[0]) exp_t = !sn[0];
            else exp_t = pie[0] && (pick(lk) > pick(ik)) && (!eq[0] || rs[0]);
            step();
            if (nr[0]) chk("R7 nmi", {31'd0, e_take}, {31'd0, exp_t});
            else if (!pie[0] || pick(lk) <= pick(ik))
                chk("R8 refused", {31'd0, e_take}, {31'd0, exp_t});
            else chk("R9 set rule", {31'd0, e_take}, {31'd0, exp_t});
            ext_req = 1'b0;
            #1;
            chk("R6 wake drops", {31'd0, e_wake}, 32'd0);
            step();
            chk("R11 no req no take", {31'd0, e_take}, 32'd0);
        end

        // R10 in external variant with held NMI
        ext_nmi = 1'b1;
        st_nmi  = 1'b0;
        ext_req = 1'b1;
        step();
        chk("R10 ext pulse", {31'd0, e_take}, 32'd1);
        step();
        chk("R10 ext gap", {31'd0, e_take}, 32'd0);
        ext_req = 1'b0;
        step();

        // R1 reset clears registers after activity
        en_wdata = 32'h1234_5678;
        en_we = 1'b1;
        irq_lines = 32'h0000_00F0;
        step();
        en_we = 1'b0;
        rst = 1'b1;
        step();
        rst = 1'b0;
        irq_lines = 32'd0;
        chk("R1 pend cleared", i_pend, 32'd0);
        chk("R1 enab cleared", i_enab, 32'd0);
        chk("R1 take cleared", {31'd0, i_take}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule